// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides the operating mode of a CAN controller: normal, frozen (configuration or debug) or disabled (low power). The host asks for freeze by setting a freeze-enable control together with a debug halt condition, and asks for disable with a disable control. The sequencer does not switch modes at once. First it waits for a quiet point on the bus. Then it waits for the protocol engine's internal work to drain. Only then does it raise its acknowledge and not-ready status.

While frozen or disabled, the block isolates the protocol engine from the bus. It also opens or closes write access to two protected host registers. In disable it requests that the clocks of the protocol engine and the host-interface sub-units be stopped. When freeze ends, the transmitter stays recessive until the receiver has seen a run of recessive bits, so that the controller joins the bus cleanly.

Top module: `can_mode_seq`

## Requirements
- R1: The freeze wish is `frz_en & halt_req`. After a freeze or disable request, `frz_ack` rises only when the safe-point wait (R3) and the drain wait (R4) are both complete. It is then visible in the cycle after the clock edge on which the drain condition was sampled true.
- R2: While frozen, `frz_ack`=1, `not_rdy`=1, `lpm_ack`=0 and `clk_stop`=0.
- R3: A mode entry leaves its bus wait on the first edge where at least one of these holds: `bus_idle`=1, `bus_off`=1, or `ims3_rec`=1 (the third intermission bit sampled recessive). If every request is withdrawn during the entry wait, the block returns to normal.
- R4: After the bus wait, entry holds until every bit of `busy` is 0. Each bit of `busy` is one internal activity (arbitration, matching, active move-in, move-out). A move-in that is queued but not yet started is not represented in `busy`.
- R5: In freeze, disable and resynchronisation, `tx_out`=1 (recessive). Otherwise `tx_out` follows `tx_core`. In freeze and disable, `rx_to_pe`=1; otherwise it follows `rx_in`.
- R6: `ecr_wr_en` = `ecr_wr_req` only while frozen, and 0 otherwise. `clksrc_wr_en` = `clksrc_wr_req` except while frozen, when it is 0.
- R7: When the freeze wish drops while frozen and `dis_req`=0, `frz_ack` falls on the next edge. The block then enters resynchronisation with `not_rdy`=1.
- R8: Resynchronisation ends on the edge where the 11th consecutive recessive `rx_in` sample is taken. A sample is taken only when `sample_stb`=1. A dominant sample (0) restarts the count at zero.
- R9: Setting `dis_req` while frozen gives `lpm_ack`=1, `clk_stop`=1 and `frz_ack`=0 on the next edge, with no bus wait.
- R10: A disable request from normal operation passes the same R3 and R4 waits. It then gives `lpm_ack`=1, `clk_stop`=1 and `not_rdy`=1.
- R11: When disable and the freeze wish are both present, disable wins. Clearing `dis_req` drops `lpm_ack` and `clk_stop` on the next edge. If the freeze wish is still present, the block re-runs the R3 and R4 entry before `frz_ack` rises; otherwise it enters resynchronisation.
- R12: After reset the block is in normal mode, with `frz_ack`, `lpm_ack`, `not_rdy` and `clk_stop` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_en | input | 1 | Host freeze enable |
| halt_req | input | 1 | Debug halt condition |
| dis_req | input | 1 | Host disable request |
| bus_idle | input | 1 | Bus is idle |
| bus_off | input | 1 | Controller is bus-off |
| ims3_rec | input | 1 | Third intermission bit sampled recessive |
| busy | input | NACT | Internal activity flags |
| sample_stb | input | 1 | Bit sample-point strobe |
| rx_in | input | 1 | Receive line from the bus |
| tx_core | input | 1 | Transmit bit from the protocol engine |
| ecr_wr_req | input | 1 | Host write to error counters |
| clksrc_wr_req | input | 1 | Host write to clock-source select |
| frz_ack | output | 1 | Freeze acknowledge |
| lpm_ack | output | 1 | Low-power (disable) acknowledge |
| not_rdy | output | 1 | Controller not participating on the bus |
| clk_stop | output | 1 | Stop request for sub-unit clocks |
| tx_out | output | 1 | Transmit line to the bus |
| rx_to_pe | output | 1 | Receive bit to the protocol engine |
| ecr_wr_en | output | 1 | Gated error-counter write |
| clksrc_wr_en | output | 1 | Gated clock-source write |

## Verification
The assertions assume that `busy`, the bus-status flags and the strobe are synchronous to `clk` and stable between edges. They also assume that host requests move only between edges. The stimulus drives every input on the falling edge and holds it for at least one full cycle. The bench keeps a request asserted while a bus or drain wait is pending, so that the waits themselves are observed. Both recessive runs that are cut short by a dominant sample and runs that complete are driven during resynchronisation.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_BUSWT  = 3'd1,
    MODE_DRAIN  = 3'd2,
    MODE_FROZEN = 3'd3,
    MODE_OFF    = 3'd4,
    MODE_RESYNC = 3'd5
  } mode_e;
endpackage

// File: rtl/can_safe_point.sv
module can_safe_point #(
  parameter int NACT = 4
) (
  input  logic            bus_idle,
  input  logic            bus_off,
  input  logic            ims3_rec,
  input  logic [NACT-1:0] busy,
  output logic            bus_quiet,
  output logic            drained
);
  always_comb begin
    bus_quiet = bus_idle | bus_off | ims3_rec;
    drained   = ~(|busy);
  end
endmodule

// File: rtl/can_resync_cnt.sv
module can_resync_cnt #(
  parameter int RESYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sample_stb,
  input  logic rx_in,
  output logic done
);
  localparam int CW = $clog2(RESYNC_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(RESYNC_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ~active | sample_stb;
    if (!active)     cnt_d = '0;
    else if (!rx_in) cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
    done = active & sample_stb & rx_in & (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frz_want,
  input  logic  dis_req,
  input  logic  bus_quiet,
  input  logic  drained,
  input  logic  resync_done,
  output mode_e mode
);
  mode_e mode_q, mode_d;
  logic  any_req;

  always_comb begin
    any_req = frz_want | dis_req;
    mode_d  = mode_q;
    unique case (mode_q)
      MODE_RUN:    if (any_req) mode_d = MODE_BUSWT;
      MODE_BUSWT:  if (!any_req) mode_d = MODE_RUN;
                   else if (bus_quiet) mode_d = MODE_DRAIN;
      MODE_DRAIN:  if (!any_req) mode_d = MODE_RUN;
                   else if (drained) mode_d = dis_req ? MODE_OFF : MODE_FROZEN;
      MODE_FROZEN: if (dis_req) mode_d = MODE_OFF;
                   else if (!frz_want) mode_d = MODE_RESYNC;
      MODE_OFF:    if (!dis_req) mode_d = frz_want ? MODE_BUSWT : MODE_RESYNC;
      MODE_RESYNC: if (any_req) mode_d = MODE_BUSWT;
                   else if (resync_done) mode_d = MODE_RUN;
      default:     mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int NACT        = 4,
  parameter int RESYNC_BITS = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frz_en,
  input  logic            halt_req,
  input  logic            dis_req,
  input  logic            bus_idle,
  input  logic            bus_off,
  input  logic            ims3_rec,
  input  logic [NACT-1:0] busy,
  input  logic            sample_stb,
  input  logic            rx_in,
  input  logic            tx_core,
  input  logic            ecr_wr_req,
  input  logic            clksrc_wr_req,
  output logic            frz_ack,
  output logic            lpm_ack,
  output logic            not_rdy,
  output logic            clk_stop,
  output logic            tx_out,
  output logic            rx_to_pe,
  output logic            ecr_wr_en,
  output logic            clksrc_wr_en
);
  mode_e mode;
  logic  bus_quiet, drained, resync_done, frz_want;
  logic  in_frz, in_off, in_sync, isolated;

  assign frz_want = frz_en & halt_req;

  can_safe_point #(.NACT(NACT)) u_safe (
    .bus_idle (bus_idle),
    .bus_off  (bus_off),
    .ims3_rec (ims3_rec),
    .busy     (busy),
    .bus_quiet(bus_quiet),
    .drained  (drained)
  );

  can_resync_cnt #(.RESYNC_BITS(RESYNC_BITS)) u_resync (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_sync),
    .sample_stb(sample_stb),
    .rx_in     (rx_in),
    .done      (resync_done)
  );

  can_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frz_want   (frz_want),
    .dis_req    (dis_req),
    .bus_quiet  (bus_quiet),
    .drained    (drained),
    .resync_done(resync_done),
    .mode       (mode)
  );

  always_comb begin
    in_frz       = (mode == MODE_FROZEN);
    in_off       = (mode == MODE_OFF);
    in_sync      = (mode == MODE_RESYNC);
    isolated     = in_frz | in_off;
    frz_ack      = in_frz;
    lpm_ack      = in_off;
    clk_stop     = in_off;
    not_rdy      = isolated | in_sync;
    tx_out       = (isolated | in_sync) ? 1'b1 : tx_core;
    rx_to_pe     = isolated ? 1'b1 : rx_in;
    ecr_wr_en    = ecr_wr_req & in_frz;
    clksrc_wr_en = clksrc_wr_req & ~in_frz;
  end
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
  parameter int NACT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dis_req,
  input logic [NACT-1:0] busy,
  input logic            frz_ack,
  input logic            lpm_ack,
  input logic            not_rdy,
  input logic            tx_out,
  input logic            ecr_wr_en
);
  assert_ack_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frz_ack && lpm_ack));

  assert_tx_recessive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_ack || lpm_ack) |-> tx_out);

  assert_drained_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(busy == '0));

  assert_ecr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_wr_en |-> frz_ack);

  assert_resync_notrdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frz_ack) && !lpm_ack) |-> not_rdy);

  assert_off_notrdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_ack |-> not_rdy);

  assert_off_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpm_ack) |-> $past(dis_req));
endmodule

bind can_mode_seq can_mode_seq_chk #(.NACT(NACT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dis_req  (dis_req),
  .busy     (busy),
  .frz_ack  (frz_ack),
  .lpm_ack  (lpm_ack),
  .not_rdy  (not_rdy),
  .tx_out   (tx_out),
  .ecr_wr_en(ecr_wr_en)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  localparam int NACT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frz_en = 0, halt_req = 0, dis_req = 0;
  logic bus_idle = 0, bus_off = 0, ims3_rec = 0;
  logic [NACT-1:0] busy = '0;
  logic sample_stb = 0, rx_in = 1, tx_core = 0;
  logic ecr_wr_req = 0, clksrc_wr_req = 0;
  logic frz_ack, lpm_ack, not_rdy, clk_stop, tx_out, rx_to_pe, ecr_wr_en, clksrc_wr_en;

  int errors = 0, checks = 0, cycles = 0;
  int m_mode = 0;   // 0 run,1 bus wait,2 drain,3 frozen,4 off,5 resync
  int m_run  = 0;   // recessive samples seen in resync

  always #2 clk = ~clk;

  can_mode_seq #(.NACT(NACT), .RESYNC_BITS(11)) dut (.*);

  // reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_run <= 0;
    end else begin
      automatic bit fw  = frz_en && halt_req;
      automatic bit req = fw || dis_req;
      automatic int nm  = m_mode;
      automatic int nr  = 0;
      case (m_mode)
        0: if (req) nm = 1;
        1: if (!req) nm = 0; else if (bus_idle || bus_off || ims3_rec) nm = 2;
        2: if (!req) nm = 0; else if (busy == 0) nm = dis_req ? 4 : 3;
        3: if (dis_req) nm = 4; else if (!fw) nm = 5;
        4: if (!dis_req) nm = fw ? 1 : 5;
        5: begin
          nr = m_run;
          if (sample_stb) nr = rx_in ? m_run + 1 : 0;
          if (req) begin nm = 1; nr = 0; end
          else if (nr >= 11) begin nm = 0; nr = 0; end
        end
        default: nm = 0;
      endcase
      m_mode <= nm; m_run <= nr;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    cycles++;
    if (rst_n) begin
      automatic bit fr = (m_mode == 3), of = (m_mode == 4), sy = (m_mode == 5);
      chk("R1/R2 frz_ack", frz_ack, fr);
      chk("R9/R10 lpm_ack", lpm_ack, of);
      chk("R9/R10 clk_stop", clk_stop, of);
      chk("R2/R7 not_rdy", not_rdy, fr || of || sy);
      chk("R5 tx_out", tx_out, (fr || of || sy) ? 1'b1 : tx_core);
      chk("R5 rx_to_pe", rx_to_pe, (fr || of) ? 1'b1 : rx_in);
      chk("R6 ecr_wr_en", ecr_wr_en, ecr_wr_req && fr);
      chk("R6 clksrc_wr_en", clksrc_wr_en, clksrc_wr_req && !fr);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rx_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_in = v; sample_stb = 1;
      @(negedge clk); sample_stb = 0;
    end
  endtask

  initial begin
    #5000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    // R12 reset state
    chk("R12 frz_ack", frz_ack, 1'b0);
    chk("R12 lpm_ack", lpm_ack, 1'b0);
    chk("R12 not_rdy", not_rdy, 1'b0);
    chk("R12 clk_stop", clk_stop, 1'b0);
    rst_n = 1;
    // normal traffic, gating R5/R6
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tx_core = i[0]; rx_in = i[1]; ecr_wr_req = i[0]; clksrc_wr_req = i[1];
    end
    rx_in = 1; ecr_wr_req = 0; clksrc_wr_req = 0;
    // R1: frz_en alone is not a freeze wish
    @(negedge clk); frz_en = 1; cyc(3);
    // R3: freeze with bus busy, then third intermission bit recessive
    @(negedge clk); halt_req = 1; busy = 4'b0101; cyc(4);
    @(negedge clk); ims3_rec = 1;
    @(negedge clk); ims3_rec = 0; cyc(3);
    // R4: drain the activities one by one
    @(negedge clk); busy = 4'b0100; cyc(2);
    @(negedge clk); busy = 4'b0000; cyc(2);
    chk("R1 frz_ack after drain", frz_ack, 1'b1);
    // R6 writes while frozen, R5 isolation
    @(negedge clk); ecr_wr_req = 1; clksrc_wr_req = 1; rx_in = 0; tx_core = 0;
    @(negedge clk); ecr_wr_req = 0; clksrc_wr_req = 0; rx_in = 1;
    // R7: halt removed -> resync; R8 interrupted run then full run
    @(negedge clk); halt_req = 0;
    @(negedge clk);
    chk("R7 frz_ack fell", frz_ack, 1'b0);
    chk("R7 not_rdy in resync", not_rdy, 1'b1);
    rx_bits(7, 1); rx_bits(1, 0); rx_bits(10, 1);
    chk("R8 still resync after 10", not_rdy, 1'b1);
    rx_bits(1, 1);
    chk("R8 normal after 11", not_rdy, 1'b0);
    // R10: disable from normal, bus-off qualifies
    @(negedge clk); dis_req = 1; busy = 4'b1000; cyc(3);
    @(negedge clk); bus_off = 1; cyc(2);
    @(negedge clk); busy = 0; bus_off = 0; cyc(2);
    chk("R10 lpm_ack", lpm_ack, 1'b1);
    // R11: freeze wish added while off, then disable cleared
    @(negedge clk); halt_req = 1; cyc(2);
    @(negedge clk); dis_req = 0;
    @(negedge clk);
    chk("R11 lpm_ack dropped", lpm_ack, 1'b0);
    chk("R11 no frz_ack yet", frz_ack, 1'b0);
    @(negedge clk); bus_idle = 1; cyc(3);
    chk("R11 frz after re-entry", frz_ack, 1'b1);
    // R9: disable while frozen
    @(negedge clk); dis_req = 1;
    @(negedge clk);
    chk("R9 lpm_ack", lpm_ack, 1'b1);
    chk("R9 frz_ack low", frz_ack, 1'b0);
    // clear everything -> resync -> normal
    @(negedge clk); dis_req = 0; halt_req = 0; frz_en = 0; bus_idle = 0;
    rx_bits(12, 1);
    // R3 withdrawal during bus wait
    @(negedge clk); dis_req = 1; cyc(3);
    @(negedge clk); dis_req = 0; cyc(3);
    // R11 both requested together: disable wins
    @(negedge clk); dis_req = 1; frz_en = 1; halt_req = 1; bus_idle = 1; cyc(4);
    chk("R11 disable wins", lpm_ack, 1'b1);
    cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule